// File: doc/BRIEF.md
# Data Memory Access Unit

This block is the data side of a processor with separate instruction and data storage. It holds two address registers, a data pointer and a stack pointer. Both are loaded from the shared system bus, each under its own load enable. The stack pointer can also step up or down by one, for subroutine entry and return. An address multiplexer picks which pointer addresses the internal data memory for reads.

Writes always go to the location held by the data pointer. The written word comes straight from the system bus. Reads are synchronous: the addressed word appears on the memory-output port one cycle after the read strobe, and it stays there until the next read. A data register captures that word when its load input is asserted. The data register drives its content back toward the system bus at all times. The control sequencer outside this block issues the data-register load one cycle after the read.

Top module: `dmem_access_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the data pointer clears to 0, the stack pointer is set to all ones (63 at the default 6-bit address), and both `mem_out` and `dreg_out` clear to 0.
- R2: When `dptr_load` is high at a clock edge, the data pointer takes `bus_in[ADDR_W-1:0]`. After that edge, `mem_addr` shows this value while `addr_sel` is 0.
- R3: When `sptr_load` is high at a clock edge, the stack pointer takes `bus_in[ADDR_W-1:0]`, whatever the values of `sptr_inc` and `sptr_dec`.
- R4: Without a load, the stack pointer grows by one when only `sptr_inc` is high and shrinks by one when only `sptr_dec` is high, wrapping modulo 2^ADDR_W. With both high, or neither, it holds its value.
- R5: `mem_addr` combinationally shows the data pointer when `addr_sel` is 0 and the stack pointer when `addr_sel` is 1.
- R6: When `wr_en` is high at a clock edge, `bus_in` is stored at the location held by the data pointer, whatever the value of `addr_sel`.
- R7: When `rd_en` is high and `wr_en` is low at a clock edge, `mem_out` shows the word stored at `mem_addr` after that edge. Otherwise `mem_out` keeps its value.
- R8: When `rd_en` and `wr_en` are both high in one cycle, only the write takes place, and `mem_out` does not change.
- R9: When `dreg_load` is high at a clock edge, `dreg_out` takes the value `mem_out` had before that edge. Otherwise `dreg_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_in | input | DATA_W | System-bus value; source of pointer loads and write data |
| dptr_load | input | 1 | Load the data pointer from the bus |
| sptr_load | input | 1 | Load the stack pointer from the bus |
| sptr_inc | input | 1 | Increment the stack pointer |
| sptr_dec | input | 1 | Decrement the stack pointer |
| addr_sel | input | 1 | Read address source: 0 data pointer, 1 stack pointer |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| dreg_load | input | 1 | Load the data register from the memory output |
| mem_addr | output | ADDR_W | Selected memory address |
| mem_out | output | DATA_W | Registered read data of the memory |
| dreg_out | output | DATA_W | Data-register content driven toward the bus |

## Verification
A wrong pointer value shows on `mem_addr` in the same cycle, as soon as `addr_sel` selects that pointer. It also shows one edge later as a wrong word on `mem_out` after a read. A corrupted memory word stays hidden until a read of that location, and then shows on `mem_out` one edge after the strobe. A bad data-register capture shows on `dreg_out` one edge after the load. The bench therefore compares all three outputs on every cycle against a reference model, and also reads back every location after the fill.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    localparam int DMA_DATA_W = 32;
    localparam int DMA_ADDR_W = 6;

    typedef enum logic {
        SRC_DPTR = 1'b0,
        SRC_SPTR = 1'b1
    } addr_src_e;

    typedef enum logic [1:0] {
        SP_HOLD = 2'd0,
        SP_LOAD = 2'd1,
        SP_INC  = 2'd2,
        SP_DEC  = 2'd3
    } sp_op_e;

    typedef struct packed {
        logic load;
        logic inc;
        logic dec;
    } sp_ctrl_t;

    // Bus load wins; inc and dec together cancel.
    function automatic sp_op_e decode_sp_op(input sp_ctrl_t c);
        if (c.load)
            return SP_LOAD;
        else if (c.inc && !c.dec)
            return SP_INC;
        else if (c.dec && !c.inc)
            return SP_DEC;
        else
            return SP_HOLD;
    endfunction

endpackage

// File: rtl/dmem_ptr_regs.sv
module dmem_ptr_regs
    import dmem_pkg::*;
#(
    parameter int ADDR_W = DMA_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              dptr_load,
    input  sp_ctrl_t          sp_ctrl,
    input  addr_src_e         src,
    output logic [ADDR_W-1:0] dptr,
    output logic [ADDR_W-1:0] rd_addr
);

    localparam logic [ADDR_W-1:0] SP_INIT = '1;
    localparam logic [ADDR_W-1:0] ONE     = ADDR_W'(1);

    logic [ADDR_W-1:0] dptr_q;
    logic [ADDR_W-1:0] sptr_q;
    sp_op_e            sp_op;

    assign sp_op = decode_sp_op(sp_ctrl);

    always_ff @(posedge clk) begin
        if (rst)
            dptr_q <= '0;
        else if (dptr_load)
            dptr_q <= load_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sptr_q <= SP_INIT;
        end else begin
            unique case (sp_op)
                SP_LOAD: sptr_q <= load_val;
                SP_INC:  sptr_q <= sptr_q + ONE;
                SP_DEC:  sptr_q <= sptr_q - ONE;
                default: sptr_q <= sptr_q;
            endcase
        end
    end

    assign dptr    = dptr_q;
    assign rd_addr = (src == SRC_SPTR) ? sptr_q : dptr_q;

    // R2
    dptr_load_chk: assert property (@(posedge clk) disable iff (rst)
        dptr_load |=> dptr_q == $past(load_val));

    // R3
    sptr_load_chk: assert property (@(posedge clk) disable iff (rst)
        sp_ctrl.load |=> sptr_q == $past(load_val));

    // R4
    sptr_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (!sp_ctrl.load && sp_ctrl.inc && !sp_ctrl.dec) |=> sptr_q == $past(sptr_q) + ONE);

    // R4
    sptr_cancel_chk: assert property (@(posedge clk) disable iff (rst)
        (!sp_ctrl.load && sp_ctrl.inc && sp_ctrl.dec) |=> $stable(sptr_q));

endmodule

// File: rtl/dmem_array.sv
module dmem_array
    import dmem_pkg::*;
#(
    parameter int DATA_W = DMA_DATA_W,
    parameter int ADDR_W = DMA_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];
    logic [DATA_W-1:0] rd_q;
    logic              rd_fire;

    // A write in the same cycle suppresses the read.
    assign rd_fire = rd_en && !wr_en;

    always_ff @(posedge clk) begin
        if (wr_en)
            store[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_q <= '0;
        else if (rd_fire)
            rd_q <= store[rd_addr];
    end

    assign rd_data = rd_q;

    // R8
    rd_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> $stable(rd_q));

    // R7
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_q));

endmodule

// File: rtl/dmem_data_reg.sv
module dmem_data_reg
    import dmem_pkg::*;
#(
    parameter int DATA_W = DMA_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] dr_q;

    always_ff @(posedge clk) begin
        if (rst)
            dr_q <= '0;
        else if (load)
            dr_q <= din;
    end

    assign dout = dr_q;

    // R9
    dreg_capture_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> dr_q == $past(din));

    // R9
    dreg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(dr_q));

endmodule

// File: rtl/dmem_access_unit.sv
module dmem_access_unit
    import dmem_pkg::*;
#(
    parameter int DATA_W = DMA_DATA_W,
    parameter int ADDR_W = DMA_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              dptr_load,
    input  logic              sptr_load,
    input  logic              sptr_inc,
    input  logic              sptr_dec,
    input  logic              addr_sel,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              dreg_load,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_out,
    output logic [DATA_W-1:0] dreg_out
);

    sp_ctrl_t          sp_ctrl;
    addr_src_e         src;
    logic [ADDR_W-1:0] dptr;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    assign sp_ctrl = '{load: sptr_load, inc: sptr_inc, dec: sptr_dec};
    assign src     = addr_src_e'(addr_sel);

    dmem_ptr_regs #(.ADDR_W(ADDR_W)) u_ptrs (
        .clk       (clk),
        .rst       (rst),
        .load_val  (bus_in[ADDR_W-1:0]),
        .dptr_load (dptr_load),
        .sp_ctrl   (sp_ctrl),
        .src       (src),
        .dptr      (dptr),
        .rd_addr   (rd_addr)
    );

    dmem_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (dptr),
        .wr_data (bus_in),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    dmem_data_reg #(.DATA_W(DATA_W)) u_dreg (
        .clk  (clk),
        .rst  (rst),
        .load (dreg_load),
        .din  (rd_data),
        .dout (dreg_out)
    );

    assign mem_addr = rd_addr;
    assign mem_out  = rd_data;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (mem_out == '0 && dreg_out == '0));

endmodule

// File: tb/dmem_access_unit_tb.sv
module dmem_access_unit_tb;

    localparam int DW    = 32;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic [DW-1:0] bus_in;
    logic          dptr_load, sptr_load, sptr_inc, sptr_dec;
    logic          addr_sel, rd_en, wr_en, dreg_load;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_out, dreg_out;

    int n_chk  = 0;
    int n_fail = 0;

    logic [DW-1:0] m_mem [DEPTH];
    logic [AW-1:0] m_dptr, m_sptr;
    logic [DW-1:0] m_out, m_dreg;

    always #2 clk = ~clk;

    dmem_access_unit #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
        .clk (clk), .rst (rst), .bus_in (bus_in),
        .dptr_load (dptr_load), .sptr_load (sptr_load),
        .sptr_inc (sptr_inc), .sptr_dec (sptr_dec),
        .addr_sel (addr_sel), .rd_en (rd_en), .wr_en (wr_en),
        .dreg_load (dreg_load), .mem_addr (mem_addr),
        .mem_out (mem_out), .dreg_out (dreg_out)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr(input logic sel);
        return sel ? m_sptr : m_dptr;
    endfunction

    function automatic logic [AW-1:0] next_sp(input logic ld, input logic inc, input logic dec,
                                               input logic [AW-1:0] v);
        if (ld)              return bus_in[AW-1:0];
        else if (inc && !dec) return v + 1'b1;
        else if (dec && !inc) return v - 1'b1;
        return v;
    endfunction

    // One clock: drive at negedge, update the model, compare after the edge.
    task automatic step(input string tag, input logic dl, input logic sl, input logic si,
                        input logic sd, input logic sel, input logic rd, input logic wr,
                        input logic drl, input logic [DW-1:0] bus);
        logic [DW-1:0] nxt_out;
        @(negedge clk);
        dptr_load = dl; sptr_load = sl; sptr_inc = si; sptr_dec = sd;
        addr_sel = sel; rd_en = rd; wr_en = wr; dreg_load = drl; bus_in = bus;
        #0.5;
        check({tag, "/R5 addr before edge"}, DW'(mem_addr), DW'(exp_addr(sel)));
        nxt_out = (rd && !wr) ? m_mem[exp_addr(sel)] : m_out;
        if (drl) m_dreg = m_out;
        if (wr)  m_mem[m_dptr] = bus;
        m_out  = nxt_out;
        m_sptr = next_sp(sl, si, sd, m_sptr);
        if (dl) m_dptr = bus[AW-1:0];
        @(posedge clk);
        #1;
        check({tag, "/R5 addr"}, DW'(mem_addr), DW'(exp_addr(sel)));
        check({tag, "/R7 mem_out"}, mem_out, m_out);
        check({tag, "/R9 dreg_out"}, dreg_out, m_dreg);
    endtask

    task automatic idle(input string tag, input logic sel);
        step(tag, 0, 0, 0, 0, sel, 0, 0, 0, '0);
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1;
        {dptr_load, sptr_load, sptr_inc, sptr_dec, addr_sel, rd_en, wr_en, dreg_load} = '0;
        bus_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_dptr = '0; m_sptr = '1; m_out = '0; m_dreg = '0;
        // R1: reset state of both pointers and both data outputs
        #0.5;
        check("R1 dptr", DW'(mem_addr), 32'd0);
        addr_sel = 1'b1;
        #0.5;
        check("R1 sptr", DW'(mem_addr), 32'd63);
        check("R1 mem_out", mem_out, '0);
        check("R1 dreg", dreg_out, '0);

        // R2 / R6: fill every word; write with addr_sel=1 still targets dptr
        for (int i = 0; i < DEPTH; i++) begin
            step("R2", 1, 0, 0, 0, 0, 0, 0, 0, 32'(i));
            step("R6", 0, 0, 0, 0, 1, 0, 1, 0, 32'hA5000000 ^ (32'(i) * 32'h01010101));
        end
        // R7 / R9: read back through the stack pointer, then load dreg
        for (int i = 0; i < DEPTH; i++) begin
            step("R3", 0, 1, 0, 0, 1, 0, 0, 0, 32'(DEPTH - 1 - i));
            step("R7", 0, 0, 0, 0, 1, 1, 0, 0, '0);
            step("R9", 0, 0, 0, 0, 1, 0, 0, 1, '0);
        end
        // R8: read and write together: mem_out unchanged, write lands
        step("R2", 1, 0, 0, 0, 0, 0, 0, 0, 32'd5);
        step("R8", 0, 0, 0, 0, 0, 1, 1, 0, 32'hDEADBEEF);
        step("R8", 0, 0, 0, 0, 0, 1, 0, 0, '0);
        check("R8 readback", mem_out, 32'hDEADBEEF);
        // R3: load wins over inc and dec
        step("R3", 0, 1, 1, 0, 1, 0, 0, 0, 32'd20);
        check("R3 load over inc", DW'(mem_addr), 32'd20);
        step("R3", 0, 1, 0, 1, 1, 0, 0, 0, 32'd63);
        // R4: wrap up, wrap down, cancel
        step("R4", 0, 0, 1, 0, 1, 0, 0, 0, '0);
        check("R4 wrap up", DW'(mem_addr), 32'd0);
        step("R4", 0, 0, 0, 1, 1, 0, 0, 0, '0);
        check("R4 wrap down", DW'(mem_addr), 32'd63);
        step("R4", 0, 0, 1, 1, 1, 0, 0, 0, '0);
        check("R4 cancel", DW'(mem_addr), 32'd63);
        idle("R9 hold", 0);

        // Random traffic
        for (int k = 0; k < 3000; k++) begin
            logic [7:0] r;
            r = 8'($urandom);
            step("RND", r[0] & r[1], r[2] & r[3], r[4], r[5], r[6],
                 ($urandom % 2) == 0, ($urandom % 4) == 0, r[7], $urandom);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule